// File: doc/BRIEF.md
# Gated Dual-Mode Integrating Decimator

This block accumulates the one-bit output of a sigma-delta or incremental converter's comparator. The accumulated value is captured into a 16-bit result that software reads as two bytes. After reset it runs as a cascade of two integrators. The first integrator counts up on a comparator one and down on a zero. The second integrator sums the first. This gives the front half of a sinc-squared decimation, and the comb stages are left to later processing. One control bit turns the datapath into a single 16-bit counter for incremental conversion. In that mode the counter advances only while a gating pulse is high. The gating pulse is usually a PWM whose high time is the conversion window.

The block has four comparator columns. Each column has a one-cycle sample strobe that is synchronous to the system clock. A bank of sixteen asynchronous digital-block signals supplies both the gate and the capture timer. Two control registers select the data column, the gate column, the gate signal, the timer signal, the capture edge and the mode. The gate and timer signals pass through two-flop synchronisers. The timer is then edge-detected, and the chosen edge copies the active accumulator into the result register.

Top module: `gated_decimator`

## Requirements
- R1: After reset, control register 0 (address 0), control register 1 (address 1) and both result bytes (addresses 2 and 3) read 0x00. The block starts in double-integrate mode.
- R2: Double-integrate mode is selected when control register 1 bit 7 = 0. On each strobe of the data column, the first integrator changes by +1 for a comparator 1 and by -1 for a 0. The second integrator then adds the updated first-integrator value, and the second integrator is what gets captured.
- R3: Single-integrate mode is selected when control register 1 bit 7 = 1. On each strobe of the data column, while the synchronised gate is high, the counter adds 1 when the comparator of the gate column is 1. The gate column is control register 0 bits 5:4, and the counter is what gets captured.
- R4: In single-integrate mode, strobes that arrive while the gate is low leave the counter unchanged.
- R5: The result register loads the active accumulator on a rising edge of the selected timer, or on a falling edge when control register 1 bit 6 = 1. The opposite edge has no effect. The load is visible within three clock cycles of the input change.
- R6: The data column, and with it the strobe that is used, is control register 0 bits 2:1. Strobes on other columns are ignored.
- R7: The gate signal is bank entry {ctl1[5:3], ctl0[3]}. The timer signal is bank entry {ctl1[2:0], ctl0[0]}. Edges on other bank entries cause no capture.
- R8: Both integrators are 16 bits wide and wrap modulo 2^16.
- R9: A read of the result low byte (address 2) latches the current high byte. Address 3 returns that latched byte, so a capture between the two reads does not tear the pair.
- R10: A write to either control register clears both integrators to zero.
- R11: Both control registers are fully readable at the address where they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (used to latch the high byte) |
| reg_addr | input | 2 | Register address: 0 ctl0, 1 ctl1, 2 result low, 3 result high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| col_cmp | input | 4 | Comparator bit of each column |
| col_strobe | input | 4 | One-cycle sample strobe of each column |
| blk_sig | input | 16 | Asynchronous digital-block signals used as gate and timer |

## Verification
The assertions assume several things about the inputs. Each column strobe is a single system-clock pulse that does not coincide with a register write. The comparator bits are valid in the strobe cycle. A gate or timer level is held for longer than the synchroniser latency, so no edge is lost. The stimulus meets these assumptions as follows. It drives every input on the falling clock edge and separates strobes by idle cycles. After each change to a bank signal it waits three cycles, which lets the change settle before anything depends on it. It never picks the same bank entry for the gate and the timer.

// File: rtl/decim_pkg.sv
package decim_pkg;
    // Byte-wide register interface, result is two bytes.
    localparam int DATA_W = 8;
    localparam int ACC_W  = 2 * DATA_W;
    // Column and digital-block bank sizes follow the control field widths.
    localparam int COL_W  = 2;
    localparam int NCOL   = 1 << COL_W;
    localparam int IDX_W  = 4;
    localparam int NBLK   = 1 << IDX_W;

    localparam logic [1:0] A_CTL0   = 2'd0;
    localparam logic [1:0] A_CTL1   = 2'd1;
    localparam logic [1:0] A_RES_LO = 2'd2;
    localparam logic [1:0] A_RES_HI = 2'd3;

    // Decoded view of the two control registers.
    typedef struct packed {
        logic             single_mode;
        logic             cap_on_fall;
        logic [COL_W-1:0] data_col;
        logic [COL_W-1:0] gate_col;
        logic [IDX_W-1:0] gate_idx;
        logic [IDX_W-1:0] tmr_idx;
    } decim_cfg_t;

    // Split-field decode: each bank index takes its LSB from ctl0, the rest from ctl1.
    function automatic decim_cfg_t decode_cfg(input logic [DATA_W-1:0] c0,
                                              input logic [DATA_W-1:0] c1);
        decim_cfg_t r;
        r.single_mode = c1[7];
        r.cap_on_fall = c1[6];
        r.data_col    = c0[2:1];
        r.gate_col    = c0[5:4];
        r.gate_idx    = {c1[5:3], c0[3]};
        r.tmr_idx     = {c1[2:0], c0[0]};
        return r;
    endfunction
endpackage

// File: rtl/decim_sync2.sv
// Multi-flop synchroniser for an asynchronous level.
// Assumes the input level is held longer than STAGES clocks.
module decim_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/decim_edge_detect.sv
// Synchronises the selected timer signal and emits a one-cycle capture pulse
// on its rising edge, or on its falling edge when sel_fall is set.
// Assumes the timer holds each level for more than two clocks.
module decim_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_raw,
    input  logic sel_fall,
    output logic cap_pulse
);
    logic tmr_s;
    logic tmr_prev;
    logic rise;
    logic fall;

    decim_sync2 #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (tmr_raw),
        .q    (tmr_s)
    );

    // Hold the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_prev <= 1'b0;
        else        tmr_prev <= tmr_s;
    end

    assign rise      = tmr_s & ~tmr_prev;
    assign fall      = ~tmr_s & tmr_prev;
    assign cap_pulse = sel_fall ? fall : rise;

    // R5: with an unchanged polarity, two captures cannot follow back to back.
    p_cap_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (!cap_pulse || (sel_fall != $past(sel_fall))));
endmodule

// File: rtl/decim_integrator.sv
// Accumulator datapath. In double mode it is two cascaded integrators
// (+1/-1, then a running sum). In single mode it is a gated up-counter.
// All arithmetic wraps modulo 2^ACC_W. A clear has priority over a step.
module decim_integrator #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             single,
    input  logic             cmp_bit,
    input  logic             gate_ok,
    output logic [ACC_W-1:0] acc_out
);
    logic [ACC_W-1:0] i1, i2;
    logic [ACC_W-1:0] i1_n, i2_n;

    // Next-state of both integrators for the current mode.
    always_comb begin
        i1_n = i1;
        i2_n = i2;
        if (clr) begin
            i1_n = '0;
            i2_n = '0;
        end else if (step) begin
            if (single) begin
                if (gate_ok && cmp_bit) i1_n = i1 + 1'b1;
            end else begin
                i1_n = cmp_bit ? (i1 + 1'b1) : (i1 - 1'b1);
                i2_n = i2 + i1_n;
            end
        end
    end

    // Register the integrator state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i1 <= '0;
            i2 <= '0;
        end else begin
            i1 <= i1_n;
            i2 <= i2_n;
        end
    end

    assign acc_out = single ? i1 : i2;

    // R10: a control write leaves both integrators at zero.
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (i1 == '0 && i2 == '0));
    // R6: without a selected strobe nothing moves.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> ($stable(i1) && $stable(i2)));
    // R2: the second integrator absorbs the updated first integrator.
    p_double_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!single && step && !clr) |=> (i2 == $past(i2) + i1));
    // R3: a gated one advances the counter by exactly one.
    p_single_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (single && step && !clr && gate_ok && cmp_bit) |=> (i1 == $past(i1) + 1'b1));
    // R4: a closed gate freezes the counter.
    p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (single && step && !clr && !gate_ok) |=> ($stable(i1) && $stable(i2)));
endmodule

// File: rtl/decim_regs.sv
// Byte register file: two control registers, the captured result and the
// high-byte holding register. A read of the low byte latches the high byte.
// A write to either control register raises clr for one cycle.
module decim_regs #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_en,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [DATA_W-1:0] ctl0,
    output logic [DATA_W-1:0] ctl1,
    output logic              clr
);
    import decim_pkg::*;

    logic [ACC_W-1:0]  res_q;
    logic [DATA_W-1:0] hi_hold;

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0 <= '0;
            ctl1 <= '0;
        end else if (wr_en) begin
            if (addr == A_CTL0) ctl0 <= wdata;
            if (addr == A_CTL1) ctl1 <= wdata;
        end
    end

    assign clr = wr_en && (addr == A_CTL0 || addr == A_CTL1);

    // Capture the active accumulator on the timer edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (cap_en) res_q <= acc_in;
    end

    // Latch the high byte when the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_hold <= '0;
        else if (rd_en && addr == A_RES_LO) hi_hold <= res_q[ACC_W-1:DATA_W];
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTL0:   rdata = ctl0;
            A_CTL1:   rdata = ctl1;
            A_RES_LO: rdata = res_q[DATA_W-1:0];
            default:  rdata = hi_hold;
        endcase
    end

    // R9: the latched high byte changes only on a low-byte read.
    p_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == A_RES_LO) |=> $stable(hi_hold));
    // R5: the result changes only on a capture pulse.
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(res_q));
    // R11: the control registers change only on a write.
    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctl0) && $stable(ctl1)));
endmodule

// File: rtl/gated_decimator.sv
// Top level of the integrating decimator. It decodes the control registers,
// routes the column strobe and comparator bits, selects the gate and timer
// from the bank, synchronises them and ties the register file to the datapath.
// Assumes column strobes are single-cycle and synchronous to clk, and that the
// bank signals are asynchronous and slow relative to clk.
module gated_decimator (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr_en,
    input  logic                         reg_rd_en,
    input  logic [1:0]                   reg_addr,
    input  logic [decim_pkg::DATA_W-1:0] reg_wdata,
    output logic [decim_pkg::DATA_W-1:0] reg_rdata,
    input  logic [decim_pkg::NCOL-1:0]   col_cmp,
    input  logic [decim_pkg::NCOL-1:0]   col_strobe,
    input  logic [decim_pkg::NBLK-1:0]   blk_sig
);
    import decim_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [DATA_W-1:0] ctl0, ctl1;
    logic              clr;
    decim_cfg_t        cfg;
    logic              gate_raw, gate_s, tmr_raw, cap_pulse;
    logic              step, cmp_bit;
    logic [ACC_W-1:0]  acc;

    assign cfg      = decode_cfg(ctl0, ctl1);
    assign gate_raw = blk_sig[cfg.gate_idx];
    assign tmr_raw  = blk_sig[cfg.tmr_idx];
    assign step     = col_strobe[cfg.data_col];
    assign cmp_bit  = cfg.single_mode ? col_cmp[cfg.gate_col] : col_cmp[cfg.data_col];

    decim_regs #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .rd_en (reg_rd_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cap_en(cap_pulse),
        .acc_in(acc),
        .ctl0  (ctl0),
        .ctl1  (ctl1),
        .clr   (clr)
    );

    decim_sync2 #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (gate_raw),
        .q    (gate_s)
    );

    decim_edge_detect #(.STAGES(SYNC_STAGES)) u_tmr_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_raw  (tmr_raw),
        .sel_fall (cfg.cap_on_fall),
        .cap_pulse(cap_pulse)
    );

    decim_integrator #(.ACC_W(ACC_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .single (cfg.single_mode),
        .cmp_bit(cmp_bit),
        .gate_ok(gate_s),
        .acc_out(acc)
    );

    // R6: at most one column strobe per cycle on the selected path (input assumption).
    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_strobe));
endmodule

// File: tb/tb_gated_decimator.sv
module tb_gated_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [3:0]  col_cmp = 4'd0, col_strobe = 4'd0;
    logic [15:0] blk_sig = 16'd0;

    int n_tests = 0, n_fail = 0;
    logic [7:0]  m_c0 = 8'd0, m_c1 = 8'd0;
    logic [15:0] m_i1 = 16'd0, m_i2 = 16'd0, m_out = 16'd0;

    always #2 clk = ~clk;

    gated_decimator dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .col_cmp(col_cmp), .col_strobe(col_strobe), .blk_sig(blk_sig)
    );

    function automatic logic [3:0] gidx_f(input logic [7:0] c0, input logic [7:0] c1);
        return {c1[5:3], c0[3]};
    endfunction
    function automatic logic [3:0] tidx_f(input logic [7:0] c0, input logic [7:0] c1);
        return {c1[2:0], c0[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 2'd0) m_c0 = d;
        if (a == 2'd1) m_c1 = d;
        if (a <= 2'd1) begin m_i1 = 16'd0; m_i2 = 16'd0; end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    // Pulse one column strobe and update the model.
    task automatic strobe(input int col, input logic [3:0] cmps);
        @(negedge clk);
        col_strobe = 4'(1 << col); col_cmp = cmps;
        @(negedge clk);
        col_strobe = 4'd0;
        if (col == int'(m_c0[2:1])) begin
            if (m_c1[7]) begin
                if (blk_sig[gidx_f(m_c0, m_c1)] && cmps[m_c0[5:4]]) m_i1 = m_i1 + 16'd1;
            end else begin
                m_i1 = cmps[m_c0[2:1]] ? m_i1 + 16'd1 : m_i1 - 16'd1;
                m_i2 = m_i2 + m_i1;
            end
        end
    endtask

    // Change one bank signal and allow three clocks for it to take effect.
    task automatic set_blk(input logic [3:0] i, input logic v);
        @(negedge clk);
        blk_sig[i] = v;
        repeat (3) @(negedge clk);
    endtask

    // Drive the selected timer through idle level then the active edge.
    task automatic capture();
        logic idle;
        idle = m_c1[6];
        set_blk(tidx_f(m_c0, m_c1), idle);
        set_blk(tidx_f(m_c0, m_c1), ~idle);
        m_out = m_c1[7] ? m_i1 : m_i2;
    endtask

    task automatic check_out(input string tag);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        chk(tag, {16'd0, hi, lo}, {16'd0, m_out});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, lo_a;
        logic [15:0] a_val;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(2'd0, d); chk("R1 ctl0", {24'd0, d}, 32'd0);
        rd(2'd1, d); chk("R1 ctl1", {24'd0, d}, 32'd0);
        check_out("R1 result");

        // R11: control readback
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        rd(2'd0, d); chk("R11 ctl0", {24'd0, d}, 32'hA5);
        rd(2'd1, d); chk("R11 ctl1", {24'd0, d}, 32'h3C);

        // R2 and R6: double mode, data column 1, timer entry 2
        wr(2'd0, 8'h02); wr(2'd1, 8'h01);
        strobe(1, 4'b0010); strobe(1, 4'b0010); strobe(1, 4'b0000); strobe(1, 4'b0010);
        strobe(0, 4'b1111); strobe(2, 4'b0000); // R6: other columns ignored
        capture();
        chk("R2 model", {16'd0, m_out}, 32'd6);
        check_out("R2/R6 double sum");

        // R5: falling edge ignored in rising mode, then falling-edge capture
        set_blk(4'd2, 1'b0);
        check_out("R5 fall ignored");
        wr(2'd1, 8'h41);
        strobe(1, 4'b0010); strobe(1, 4'b0010);
        set_blk(4'd2, 1'b1);
        check_out("R5 rise ignored when inverted");
        set_blk(4'd2, 1'b0);
        m_out = m_i2;
        chk("R5 model", {16'd0, m_out}, 32'd3);
        check_out("R5 falling capture");

        // R3, R4, R7: single mode, gate column 2, gate entry 5, timer entry 2
        wr(2'd0, 8'h2A); wr(2'd1, 8'h91);
        set_blk(4'd5, 1'b1);
        repeat (3) strobe(1, 4'b0100);
        repeat (2) strobe(1, 4'b0010);
        set_blk(4'd5, 1'b0);
        repeat (4) strobe(1, 4'b1111); // R4: gate low
        capture();
        chk("R3 model", {16'd0, m_out}, 32'd3);
        check_out("R3/R4 gated count");
        set_blk(4'd5, 1'b1);
        strobe(1, 4'b0100);
        set_blk(4'd3, 1'b1); set_blk(4'd3, 1'b0); // R7: unselected entry
        check_out("R7 other entry no capture");

        // R10: rewrite clears integrators
        wr(2'd1, 8'h91);
        capture();
        check_out("R10 cleared");

        // R8: wrap in double mode (400 ones)
        wr(2'd0, 8'h02); wr(2'd1, 8'h01);
        repeat (400) strobe(1, 4'b0010);
        capture();
        chk("R8 model", {16'd0, m_out}, 32'd14664);
        check_out("R8 wrap");

        // R9: high byte held across a capture
        a_val = m_out;
        rd(2'd2, lo_a);
        strobe(1, 4'b0000);
        capture();
        rd(2'd3, d);
        chk("R9 held high byte", {24'd0, d}, {24'd0, a_val[15:8]});
        chk("R9 low byte", {24'd0, lo_a}, {24'd0, a_val[7:0]});
        check_out("R9 fresh pair");

        // Random configurations (R2, R3, R4, R6, R7)
        for (int it = 0; it < 40; it++) begin
            logic [7:0] c0, c1;
            int n;
            c0 = 8'($urandom);
            c1 = 8'($urandom);
            if (gidx_f(c0, c1) == tidx_f(c0, c1)) c0[0] = ~c0[0];
            wr(2'd0, c0); wr(2'd1, c1);
            set_blk(gidx_f(c0, c1), 1'($urandom));
            n = 5 + int'($urandom % 36);
            for (int k = 0; k < n; k++) begin
                int col;
                col = ($urandom % 4 != 0) ? int'(c0[2:1]) : int'($urandom % 4);
                strobe(col, 4'($urandom));
            end
            capture();
            check_out(c1[7] ? "R3/R4/R7 random single" : "R2/R6/R7 random double");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule